// File: doc/BRIEF.md
# Wake-Up Frame Pattern Filter

This block watches the receive byte stream of an Ethernet port and decides, frame by frame, whether a frame matches one programmed wake-up pattern. Bytes arrive one per valid cycle. A start flag marks the first destination-address byte and an end flag marks the last byte of the frame. The block does not compare the pattern bytes directly. It starts a window at a programmable byte offset, and a 128-bit select mask picks bytes inside that window. The selected bytes are hashed into a CRC-16, and the hash is compared with a programmed expected value when the frame ends.

Two optional qualifiers can also be enabled. One requires a broadcast destination address and the other requires a multicast destination address. With an offset of 12, a mask that selects the two type bytes and the broadcast qualifier on, the filter recognises address-resolution requests. With an empty mask and the multicast qualifier on, it accepts any group-addressed frame. A single-cycle pulse reports each matching frame. Firmware programs the filter through a small word-wide write port.

Top module: `wuf_filter`

## Requirements
- R1: After reset, matchPulse is low and all programmable state is zero. The filter is therefore disabled and the mask is empty, so no frame produces a match until the registers are written.
- R2: Writes take effect when wrEn is high. Address 0 is the control word: bit 15 enables the filter, bit 14 requires a broadcast destination, bit 13 requires a multicast destination, and bits 7:0 hold the window offset. Address 1 holds the expected CRC. Addresses 2 to 9 hold mask words 0 to 7. Writes to any other address change nothing.
- R3: Frame byte number offset+16k+j (byte 0 is the start-flagged byte) is selected exactly when bit j of mask word k is set, for k in 0..7 and j in 0..15.
- R4: The selected bytes, in frame order, update a CRC-16. The update uses the reflected polynomial 0xA001, starts from 0xFFFF and takes each byte least significant bit first. At end of frame, the 16-bit result is bit-reversed and compared for equality with the expected CRC.
- R5: matchPulse is high for exactly one cycle, in the cycle after the end-flagged byte is accepted. It is never high at any other time.
- R6: When the enable bit is clear, no frame matches.
- R7: With the broadcast qualifier set, a frame matches only if it has at least 6 bytes and bytes 0 to 5 are all 0xFF.
- R8: With the multicast qualifier set, a frame matches only if bit 0 of byte 0 is set.
- R9: A frame that ends before it contains the byte at the highest set mask position does not match.
- R10: With an empty mask, no byte is hashed and the compared value is 0xFFFF. The match then depends on the enable bit and the qualifiers only.
- R11: Cycles with inValid low are ignored, whatever the other stream inputs carry. A frame delivered with idle gaps matches exactly as the same frame without gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register word address |
| wrData | input | 16 | Register write data |
| inValid | input | 1 | Stream byte valid |
| inSof | input | 1 | First byte of frame flag |
| inEof | input | 1 | Last byte of frame flag |
| inByte | input | 8 | Stream byte |
| matchPulse | output | 1 | One-cycle wake-up match indication |

## Verification
Most internal faults appear only as a wrong or missing matchPulse, one cycle after the end byte of the frame that exposes them. Examples are a CRC register that is not reseeded at the start byte, a window index that is off by one, or a stale address flag. The bench therefore sends many back-to-back frames that differ in offset, mask density, length and destination type. A state error that carries over from one frame then decides the very next frame's outcome, which makes it visible. Directed frames cover the window edges, the empty mask, truncated frames and idle gaps, where such off-by-one errors show up.

// File: rtl/wuf_pkg.sv
package wuf_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 16;
  localparam int CFG_ADDR  = 0;
  localparam int EXP_ADDR  = 1;
  localparam int MASK_BASE = 2;
  localparam int DA_BYTES  = 6;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  // Control-to-datapath strobes for the hash register.
  typedef struct packed {
    logic clear;    // reseed before absorbing this byte
    logic advance;  // a frame byte is accepted this cycle
    logic feed;     // the byte is selected and goes into the hash
  } strobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] bitRev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15 - i];
    return r;
  endfunction
endpackage

// File: rtl/wuf_datapath.sv
module wuf_datapath
  import wuf_pkg::*;
#(
  parameter int MASK_WORDS = 8,
  parameter int WORD_W     = 16,
  parameter int OFFSET_W   = 8,
  localparam int WIN_BYTES = MASK_WORDS * WORD_W,
  localparam int WIN_IDX_W = $clog2(WIN_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [7:0]           inByte,
  input  strobe_t              strb,
  input  logic [WIN_IDX_W-1:0] winIdx,
  output logic                 filterEn,
  output logic                 bcastReq,
  output logic                 mcastReq,
  output logic [OFFSET_W-1:0]  offset,
  output logic                 maskBit,
  output logic                 maskAny,
  output logic [WIN_IDX_W-1:0] highIdx,
  output logic                 crcOk
);
  logic [15:0]          expCrc;
  logic [15:0]          crcReg;
  logic [15:0]          crcBase;
  logic [15:0]          crcNext;
  logic [WIN_BYTES-1:0] maskFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filterEn <= 1'b0;
      bcastReq <= 1'b0;
      mcastReq <= 1'b0;
      offset   <= '0;
      expCrc   <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(CFG_ADDR)) begin
        filterEn <= wrData[15];
        bcastReq <= wrData[14];
        mcastReq <= wrData[13];
        offset   <= wrData[OFFSET_W-1:0];
      end
      if (wrAddr == ADDR_W'(EXP_ADDR)) expCrc <= wrData[15:0];
    end
  end

  // One register per 16-byte group of the window.
  generate
    for (genvar k = 0; k < MASK_WORDS; k++) begin : g_mask
      logic [WORD_W-1:0] word;
      always_ff @(posedge clk) begin
        if (!rstN) word <= '0;
        else if (wrEn && wrAddr == ADDR_W'(MASK_BASE + k)) word <= wrData[WORD_W-1:0];
      end
      assign maskFlat[k*WORD_W +: WORD_W] = word;
    end
  endgenerate

  assign maskBit = maskFlat[winIdx];

  always_comb begin
    highIdx = '0;
    maskAny = 1'b0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (maskFlat[i]) begin
        highIdx = WIN_IDX_W'(i);
        maskAny = 1'b1;
      end
    end
  end

  assign crcBase = strb.clear ? CRC_INIT : crcReg;
  assign crcNext = strb.feed ? crcStep(crcBase, inByte) : crcBase;
  assign crcOk   = (bitRev16(crcNext) == expCrc);

  always_ff @(posedge clk) begin
    if (!rstN) crcReg <= CRC_INIT;
    else if (strb.advance) crcReg <= crcNext;
  end

  // R11
  crc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(crcReg));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(expCrc) && $stable(offset) && $stable(filterEn)));

  // R4
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && !strb.feed) |=> (crcReg == CRC_INIT));
endmodule

// File: rtl/wuf_control.sv
module wuf_control
  import wuf_pkg::*;
#(
  parameter int MASK_WORDS = 8,
  parameter int WORD_W     = 16,
  parameter int OFFSET_W   = 8,
  localparam int WIN_BYTES = MASK_WORDS * WORD_W,
  localparam int WIN_IDX_W = $clog2(WIN_BYTES),
  localparam int CNT_W     = OFFSET_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inEof,
  input  logic [7:0]           inByte,
  input  logic                 filterEn,
  input  logic                 bcastReq,
  input  logic                 mcastReq,
  input  logic [OFFSET_W-1:0]  offset,
  input  logic                 maskBit,
  input  logic                 maskAny,
  input  logic [WIN_IDX_W-1:0] highIdx,
  input  logic                 crcOk,
  output strobe_t              strb,
  output logic [WIN_IDX_W-1:0] winIdx,
  output logic                 matchPulse
);
  logic [CNT_W-1:0] byteCnt, byteIdx, relIdx, offsetExt;
  logic frameActive, inFrame, accept, inWindow;
  logic coveredReg, coveredNow, hitLast;
  logic daOnesReg, daOnesBase, daOnesNow, daFullNow;
  logic groupReg, groupNow;
  logic eofNow, matchNext;

  assign byteIdx   = inSof ? '0 : byteCnt;
  assign offsetExt = CNT_W'(offset);
  assign relIdx    = byteIdx - offsetExt;
  assign inFrame   = inSof | frameActive;
  assign accept    = inValid & inFrame;
  assign inWindow  = (byteIdx >= offsetExt) && (relIdx < CNT_W'(WIN_BYTES));
  assign winIdx    = relIdx[WIN_IDX_W-1:0];

  assign strb.clear   = inValid & inSof;
  assign strb.advance = accept;
  assign strb.feed    = accept & inWindow & maskBit;

  assign hitLast    = accept & inWindow & (winIdx == highIdx);
  assign coveredNow = !maskAny | hitLast | (coveredReg & !inSof);

  assign daOnesBase = inSof ? 1'b1 : daOnesReg;
  assign daOnesNow  = (byteIdx < CNT_W'(DA_BYTES)) ? (daOnesBase & (inByte == 8'hFF)) : daOnesBase;
  assign daFullNow  = (byteIdx >= CNT_W'(DA_BYTES - 1));
  assign groupNow   = inSof ? inByte[0] : groupReg;

  assign eofNow    = accept & inEof;
  assign matchNext = eofNow & filterEn & crcOk & coveredNow
                   & (!bcastReq | (daOnesNow & daFullNow))
                   & (!mcastReq | groupNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt     <= '0;
      frameActive <= 1'b0;
      coveredReg  <= 1'b0;
      daOnesReg   <= 1'b0;
      groupReg    <= 1'b0;
      matchPulse  <= 1'b0;
    end else begin
      matchPulse <= matchNext;
      if (accept) begin
        byteCnt     <= (&byteIdx) ? byteIdx : byteIdx + 1'b1;
        frameActive <= !inEof;
        coveredReg  <= coveredNow;
        daOnesReg   <= daOnesNow;
        groupReg    <= groupNow;
      end
    end
  end

  // R5
  match_after_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(inValid && inEof));

  // R6
  match_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(filterEn));

  // R11
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(byteCnt) && $stable(frameActive)));

  // R3
  feed_one_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.feed |-> (inValid && winIdx == relIdx[WIN_IDX_W-1:0]));
endmodule

// File: rtl/wuf_filter.sv
module wuf_filter
  import wuf_pkg::*;
#(
  parameter int MASK_WORDS = 8,
  parameter int WORD_W     = 16,
  parameter int OFFSET_W   = 8,
  localparam int WIN_IDX_W = $clog2(MASK_WORDS * WORD_W)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [7:0]  inByte,
  output logic        matchPulse
);
  strobe_t              strb;
  logic [WIN_IDX_W-1:0] winIdx, highIdx;
  logic                 filterEn, bcastReq, mcastReq, maskBit, maskAny, crcOk;
  logic [OFFSET_W-1:0]  offset;

  wuf_datapath #(.MASK_WORDS(MASK_WORDS), .WORD_W(WORD_W), .OFFSET_W(OFFSET_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inByte(inByte), .strb(strb), .winIdx(winIdx),
    .filterEn(filterEn), .bcastReq(bcastReq), .mcastReq(mcastReq), .offset(offset),
    .maskBit(maskBit), .maskAny(maskAny), .highIdx(highIdx), .crcOk(crcOk)
  );

  wuf_control #(.MASK_WORDS(MASK_WORDS), .WORD_W(WORD_W), .OFFSET_W(OFFSET_W)) ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof), .inByte(inByte),
    .filterEn(filterEn), .bcastReq(bcastReq), .mcastReq(mcastReq), .offset(offset),
    .maskBit(maskBit), .maskAny(maskAny), .highIdx(highIdx), .crcOk(crcOk),
    .strb(strb), .winIdx(winIdx), .matchPulse(matchPulse)
  );
endmodule

// File: tb/wuf_filter_tb.sv
module wuf_filter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inByte = '0;
  logic matchPulse;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // Register model
  bit mEn, mBc, mMc;
  int mOff;
  logic [15:0] mExp;
  logic [15:0] mMask [8];
  logic [7:0] fr [256];
  int frLen;

  always #2.5 clk = ~clk;

  wuf_filter dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inByte(inByte), .matchPulse(matchPulse));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 4'($urandom); wrData = 16'($urandom);
    if (a == 0) begin mEn = d[15]; mBc = d[14]; mMc = d[13]; mOff = int'(d[7:0]); end
    else if (a == 1) mExp = d;
    else if (a >= 2 && a <= 9) mMask[a-2] = d;
  endtask

  task automatic setAll(input bit en, input bit bc, input bit mc, input int off,
                        input logic [15:0] ex);
    wrReg(0, {en, bc, mc, 5'd0, 8'(off)});
    wrReg(1, ex);
  endtask

  function automatic logic [15:0] refCrc();
    logic [15:0] c = 16'hFFFF;
    logic [15:0] r;
    for (int i = 0; i < frLen; i++) begin
      int rel = i - mOff;
      if (rel >= 0 && rel < 128 && mMask[rel/16][rel%16]) begin
        c = c ^ {8'h00, fr[i]};
        for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      end
    end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return r;
  endfunction

  function automatic bit refMatch();
    int hi = -1;
    bit bcOk;
    for (int i = 0; i < 128; i++) if (mMask[i/16][i%16]) hi = i;
    if (!mEn) return 0;
    if (hi >= 0 && mOff + hi >= frLen) return 0;
    if (refCrc() != mExp) return 0;
    bcOk = (frLen >= 6);
    for (int i = 0; i < 6 && i < frLen; i++) if (fr[i] != 8'hFF) bcOk = 0;
    if (mBc && !bcOk) return 0;
    if (mMc && !fr[0][0]) return 0;
    return 1;
  endfunction

  // Sends fr[0..frLen-1]; returns the pulse seen after the end byte.
  task automatic sendFrame(input bit gaps, input string req);
    bit early = 0;
    bit got;
    bit exp = refMatch();
    for (int i = 0; i < frLen; i++) begin
      if (gaps) begin
        int g = int'($urandom % 3);
        for (int k = 0; k < g; k++) begin
          inValid = 1'b0; inSof = 1'($urandom); inEof = 1'($urandom); inByte = 8'($urandom);
          @(posedge clk); @(negedge clk);
          if (matchPulse) early = 1;
        end
      end
      inValid = 1'b1; inSof = (i == 0); inEof = (i == frLen - 1); inByte = fr[i];
      @(posedge clk); @(negedge clk);
      if (i < frLen - 1 && matchPulse) early = 1;
    end
    got = matchPulse;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    check(got == exp, req, int'(got), int'(exp));
    check(!early, {req, "/R5 no early pulse"}, int'(early), 0);
    @(posedge clk); @(negedge clk);
    check(!matchPulse, {req, "/R5 single cycle"}, int'(matchPulse), 0);
  endtask

  task automatic fillFrame(input int len, input int daType);
    frLen = len;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    if (daType == 1) for (int i = 0; i < 6 && i < len; i++) fr[i] = 8'hFF;
    else if (daType == 2) begin fr[0][0] = 1'b1; if (len > 1) fr[1] = 8'h5E; end
    else fr[0][0] = 1'b0;
  endtask

  task automatic arpSetup();
    for (int k = 0; k < 8; k++) wrReg(2 + k, 16'h0000);
    wrReg(2, 16'h0003);
    fillFrame(60, 1);
    fr[12] = 8'h08; fr[13] = 8'h06;
    wrReg(0, {1'b1, 1'b1, 1'b0, 5'd0, 8'd12});
    wrReg(1, refCrc());
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) mMask[k] = '0;
    mEn = 0; mBc = 0; mMc = 0; mOff = 0; mExp = '0;
    repeat (4) @(negedge clk);
    check(!matchPulse, "R1 pulse low in reset", int'(matchPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!matchPulse, "R1 pulse low after reset", int'(matchPulse), 0);

    // R1: reset state disabled, empty mask, expected 0 -> no match
    fillFrame(64, 1);
    sendFrame(0, "R1 reset config no match");

    // R10: empty mask, enabled, expected 0xFFFF, no qualifiers -> match
    wrReg(0, 16'h8000); wrReg(1, 16'hFFFF);
    fillFrame(20, 0);
    check(refMatch() == 1, "R10 model", int'(refMatch()), 1);
    sendFrame(0, "R10 empty mask match");
    wrReg(1, 16'h1234);
    sendFrame(0, "R10 empty mask wrong crc");

    // R8: multicast qualifier with empty mask
    setAll(1, 0, 1, 0, 16'hFFFF);
    fillFrame(30, 2);
    sendFrame(0, "R8 multicast accepted");
    fillFrame(30, 0);
    sendFrame(0, "R8 unicast rejected");

    // R3/R4/R7: two type bytes at offset 12 with broadcast destination
    arpSetup();
    sendFrame(0, "R4 type pattern match");
    fr[13] = 8'h00;
    sendFrame(0, "R3 selected byte changed");
    fr[13] = 8'h06; fr[20] = ~fr[20];
    sendFrame(0, "R3 unselected byte ignored");
    fr[2] = 8'h12;
    sendFrame(0, "R7 non-broadcast rejected");
    fr[2] = 8'hFF;

    // R9: frame ends right before the last selected byte
    frLen = 13;
    sendFrame(0, "R9 short frame no match");
    frLen = 60;

    // R6: disable
    wrReg(0, {1'b0, 1'b1, 1'b0, 5'd0, 8'd12});
    sendFrame(0, "R6 disabled no match");
    wrReg(0, {1'b1, 1'b1, 1'b0, 5'd0, 8'd12});

    // R2: writes to unused addresses change nothing
    wrReg(12, 16'hFFFF); wrReg(15, 16'h0000); wrReg(10, 16'hABCD);
    sendFrame(0, "R2 unused address ignored");

    // R11: same frame with idle gaps and junk on idle cycles
    sendFrame(1, "R11 gaps ignored");

    // R3: last window byte (offset 0, word 7 bit 15 -> byte 127)
    for (int k = 0; k < 8; k++) wrReg(2 + k, 16'h0000);
    wrReg(9, 16'h8000);
    wrReg(0, 16'h8000);
    fillFrame(128, 0);
    wrReg(1, refCrc());
    sendFrame(0, "R3 window edge byte 127");
    frLen = 127;
    sendFrame(0, "R9 one byte short of edge");

    // Random frames
    for (int n = 0; n < 300; n++) begin
      int off = ($urandom % 8 == 0) ? int'($urandom % 200) : int'($urandom % 30);
      int len = 1 + int'($urandom % 200);
      int dt = int'($urandom % 3);
      for (int k = 0; k < 8; k++)
        wrReg(2 + k, ($urandom % 2) ? 16'h0000 : 16'($urandom & $urandom));
      wrReg(0, {1'($urandom % 8 != 0), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 5'd0, 8'(off)});
      fillFrame(len, dt);
      wrReg(1, ($urandom % 4 == 0) ? 16'($urandom) : refCrc());
      sendFrame(1'($urandom % 2), "R4 random frame");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule